// File: doc/BRIEF.md
# Instruction Address Sequencer with One-Deep Return Stack

This block produces the fetch address for a small 4-bit-class controller core. Each time the core retires an instruction it pulses `step` and reports what that instruction did: run on in sequence, take a jump, call a subroutine, or return. The program counter then moves forward by the retired instruction's byte length, loads the operand address, or reloads the saved return address. The decode stage evaluates conditional jumps. A jump that is not taken is reported as a plain sequential step.

A single return-address register holds the address to resume at after a call. A nesting FSM with three states tracks whether that register is in use. NEST_EMPTY means no call is outstanding. NEST_HELD means one call is outstanding. NEST_HANG is a one-cycle trip state. The transitions are:
- call in NEST_EMPTY goes to NEST_HELD;
- return in NEST_HELD goes to NEST_EMPTY;
- call in NEST_HELD (overflow) goes to NEST_HANG;
- return in NEST_EMPTY (underflow) goes to NEST_HANG;
- NEST_HANG always goes to NEST_EMPTY.

While in NEST_HANG the block drives a system-reset request, and the program counter is already zero. The low byte of the return-address register is also a data-memory location, which software can read and write.

Top module: `iaddr_seq`

## Requirements
- R1: Reset (`rst_n` low) sets `pc` to 0, `depth` to 0 and `hang_rst` to 0. Reset leaves the return-address register unchanged, so `dm_rdata` reads the same byte after reset as before it.
- R2: With `step`=1 and `op`=2'b00 (sequential), `pc` becomes (`pc` + `ilen`) mod 2^AW at the next edge.
- R3: With `step`=1 and `op`=2'b01 (jump taken), `pc` becomes `target` at the next edge.
- R4: With `step`=1, `op`=2'b10 (call) and `depth`=0, at the next edge three things happen: the return register takes (`pc` + `ilen`) mod 2^AW, `pc` becomes `target`, and `depth` becomes 1.
- R5: With `step`=1, `op`=2'b11 (return) and `depth`=1, `pc` becomes the saved return address and `depth` becomes 0. The return register keeps its value.
- R6: A call with `depth`=1 (overflow) makes `hang_rst`=1, `pc`=0 and `depth`=0 at the next edge. The return register is left unchanged.
- R7: A return with `depth`=0 (underflow) makes `hang_rst`=1, `pc`=0 and `depth`=0 at the next edge.
- R8: `hang_rst` is high for exactly one cycle. A `step` presented during that cycle is ignored, so `pc` stays 0.
- R9: `dm_rdata` always shows bits 7:0 of the return register. With `dm_we`=1, those bits take `dm_wdata` at the next edge. The upper bits keep their value.
- R10: When a call is accepted in the same cycle as `dm_we`=1, the call's save wins over the data-memory write.
- R11: With `step`=0, `pc` and `depth` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| step | input | 1 | one instruction retired this cycle |
| op | input | 2 | 00 sequential, 01 jump, 10 call, 11 return |
| ilen | input | LW | byte length of the retired instruction |
| target | input | AW | jump or call destination |
| dm_we | input | 1 | data-memory write to the return register's low byte |
| dm_wdata | input | 8 | data-memory write value |
| dm_rdata | output | 8 | low byte of the return register |
| pc | output | AW | current program counter |
| depth | output | 1 | stack pointer: 1 while a call is outstanding |
| hang_rst | output | 1 | one-cycle system-reset request on overflow or underflow |

## Verification
Every result of a step is registered once. `pc`, `depth`, `hang_rst` and the return register therefore show the effect one clock edge after the stimulus. The only exception is `dm_rdata`, which is a combinational view of the register and follows it in the same cycle. The bench drives inputs on a falling edge and samples on the next falling edge, exactly one rising edge later. It compares against a model that tracks the program counter, the saved address and the nesting bit arithmetically. The sweep walks jump targets across the whole address space, including the top address so that wrap-around is covered. At each target it tries every instruction length, a call and a return.

// File: rtl/iaddr_seq_pkg.sv
package iaddr_seq_pkg;
    typedef enum logic [1:0] {
        OP_SEQ  = 2'b00,
        OP_JUMP = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } step_op_e;

    typedef enum logic [1:0] {
        NEST_EMPTY = 2'b00,
        NEST_HELD  = 2'b01,
        NEST_HANG  = 2'b10
    } nest_state_e;
endpackage

// File: rtl/iaddr_nest_fsm.sv
module iaddr_nest_fsm
    import iaddr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    input  step_op_e op,
    output logic     depth,
    output logic     hang_pulse,
    output logic     take_call,
    output logic     take_ret,
    output logic     trip,
    output logic     run
);
    nest_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NEST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NEST_EMPTY: begin
                if (step && op == OP_CALL)     state_d = NEST_HELD;
                else if (step && op == OP_RET) state_d = NEST_HANG;
            end
            NEST_HELD: begin
                if (step && op == OP_RET)       state_d = NEST_EMPTY;
                else if (step && op == OP_CALL) state_d = NEST_HANG;
            end
            NEST_HANG: state_d = NEST_EMPTY;
            default:   state_d = NEST_EMPTY;
        endcase
    end

    always_comb begin
        depth      = 1'b0;
        hang_pulse = 1'b0;
        take_call  = 1'b0;
        take_ret   = 1'b0;
        trip       = 1'b0;
        run        = 1'b0;
        unique case (state_q)
            NEST_EMPTY: begin
                run       = step;
                take_call = step && op == OP_CALL;
                trip      = step && op == OP_RET;
            end
            NEST_HELD: begin
                depth     = 1'b1;
                run       = step;
                take_ret  = step && op == OP_RET;
                trip      = step && op == OP_CALL;
            end
            NEST_HANG: hang_pulse = 1'b1;
            default:   hang_pulse = 1'b0;
        endcase
    end

    // R8
    hang_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang_pulse |=> !hang_pulse);

    // R6
    trip_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (hang_pulse && !depth));

    // R4
    call_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_call |=> (depth && !hang_pulse));
endmodule

// File: rtl/iaddr_next.sv
module iaddr_next
    import iaddr_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 2
) (
    input  logic [AW-1:0] pc_cur,
    input  logic [LW-1:0] ilen,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] ret_addr,
    input  step_op_e      op,
    input  logic          run,
    input  logic          trip,
    output logic [AW-1:0] seq_addr,
    output logic [AW-1:0] pc_nxt
);
    localparam logic [AW-1:0] PC_ZERO = '0;

    assign seq_addr = pc_cur + AW'(ilen);

    always_comb begin
        pc_nxt = pc_cur;
        if (trip) begin
            pc_nxt = PC_ZERO;
        end else if (run) begin
            unique case (op)
                OP_SEQ:  pc_nxt = seq_addr;
                OP_JUMP: pc_nxt = target;
                OP_CALL: pc_nxt = target;
                OP_RET:  pc_nxt = ret_addr;
                default: pc_nxt = pc_cur;
            endcase
        end
    end
endmodule

// File: rtl/iaddr_ret_store.sv
module iaddr_ret_store #(
    parameter int AW = 11,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          save_en,
    input  logic [AW-1:0] save_val,
    input  logic          dm_we,
    input  logic [MW-1:0] dm_wdata,
    output logic [AW-1:0] ret_q,
    output logic [MW-1:0] dm_rdata
);
    localparam int HW = AW - MW;

    always_ff @(posedge clk) begin
        if (save_en)    ret_q[MW-1:0] <= save_val[MW-1:0];
        else if (dm_we) ret_q[MW-1:0] <= dm_wdata;
    end

    generate
        if (HW > 0) begin : g_upper
            always_ff @(posedge clk) begin
                if (save_en) ret_q[AW-1:MW] <= save_val[AW-1:MW];
            end
        end
    endgenerate

    assign dm_rdata = ret_q[MW-1:0];

    // R10
    save_wins_chk: assert property (@(posedge clk)
        (save_en && dm_we) |=> (dm_rdata == $past(save_val[MW-1:0])));
endmodule

// File: rtl/iaddr_seq.sv
module iaddr_seq
    import iaddr_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [1:0]    op,
    input  logic [LW-1:0] ilen,
    input  logic [AW-1:0] target,
    input  logic          dm_we,
    input  logic [7:0]    dm_wdata,
    output logic [7:0]    dm_rdata,
    output logic [AW-1:0] pc,
    output logic          depth,
    output logic          hang_rst
);
    localparam int MW = 8;

    step_op_e      op_e;
    logic          take_call, take_ret, trip, run;
    logic [AW-1:0] pc_q, pc_nxt, seq_addr, ret_q;

    assign op_e = step_op_e'(op);

    iaddr_nest_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .op         (op_e),
        .depth      (depth),
        .hang_pulse (hang_rst),
        .take_call  (take_call),
        .take_ret   (take_ret),
        .trip       (trip),
        .run        (run)
    );

    iaddr_next #(.AW(AW), .LW(LW)) u_next (
        .pc_cur   (pc_q),
        .ilen     (ilen),
        .target   (target),
        .ret_addr (ret_q),
        .op       (op_e),
        .run      (run),
        .trip     (trip),
        .seq_addr (seq_addr),
        .pc_nxt   (pc_nxt)
    );

    iaddr_ret_store #(.AW(AW), .MW(MW)) u_ret (
        .clk      (clk),
        .save_en  (take_call),
        .save_val (seq_addr),
        .dm_we    (dm_we),
        .dm_wdata (dm_wdata),
        .ret_q    (ret_q),
        .dm_rdata (dm_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign pc = pc_q;

    // R2
    seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op == 2'b00 && !hang_rst) |=> (pc == $past(pc) + AW'($past(ilen))));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op == 2'b01 && !hang_rst) |=> (pc == $past(target)));

    // R5
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op == 2'b11 && depth) |=> (pc == $past(ret_q) && !depth));

    // R7
    hang_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang_rst |-> (pc == '0 && !depth));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !hang_rst) |=> ($stable(pc) && $stable(depth)));
endmodule

// File: tb/iaddr_seq_bench.sv
module iaddr_seq_bench;
    localparam int AW = 11;
    localparam int LW = 2;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [LW-1:0] ilen = '0;
    logic [AW-1:0] target = '0;
    logic          dm_we = 1'b0;
    logic [7:0]    dm_wdata = '0;
    logic [7:0]    dm_rdata;
    logic [AW-1:0] pc;
    logic          depth;
    logic          hang_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int exp_pc = 0;
    int exp_asr = 0;

    always #5 clk = ~clk;

    iaddr_seq #(.AW(AW), .LW(LW)) u_iaddr_seq (
        .clk(clk), .rst_n(rst_n), .step(step), .op(op), .ilen(ilen),
        .target(target), .dm_we(dm_we), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .pc(pc), .depth(depth), .hang_rst(hang_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic s, input logic [1:0] o, input int len,
                         input int tgt, input logic we, input int wd);
        step = s; op = o; ilen = LW'(len); target = AW'(tgt);
        dm_we = we; dm_wdata = 8'(wd);
        @(negedge clk);
        step = 1'b0; dm_we = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        done = 1'b1;
    end

    initial begin
        @(negedge clk);
        // preload return register then reset: R1
        rst_n = 1'b1;
        apply(1'b0, 2'b00, 0, 0, 1'b1, 8'hA5);
        chk("R9 dm write", dm_rdata, 8'hA5);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 pc", pc, 0);
        chk("R1 depth", depth, 0);
        chk("R1 hang", hang_rst, 0);
        chk("R1 asr kept", dm_rdata, 8'hA5);
        rst_n = 1'b1;
        exp_pc = 0;

        for (int t = 0; t < SPAN + 23; t += 23) begin
            int tg;
            tg = (t >= SPAN) ? SPAN - 1 : t;
            apply(1'b1, 2'b01, 1, tg, 1'b0, 0);
            exp_pc = tg;
            chk("R3 jump", pc, exp_pc);
            for (int l = 0; l < 4; l++) begin
                apply(1'b1, 2'b00, l, 0, 1'b0, 0);
                exp_pc = (exp_pc + l) % SPAN;
                chk("R2 seq", pc, exp_pc);
            end
            begin
                int cl, ct;
                cl = 1 + (t % 3);
                ct = (tg * 7 + 5) % SPAN;
                exp_asr = (exp_pc + cl) % SPAN;
                apply(1'b1, 2'b10, cl, ct, 1'b0, 0);
                chk("R4 call pc", pc, ct);
                chk("R4 call depth", depth, 1);
                chk("R4 call save", dm_rdata, exp_asr & 8'hFF);
                apply(1'b0, 2'b10, cl, 0, 1'b0, 0);
                chk("R11 idle pc", pc, ct);
                chk("R11 idle depth", depth, 1);
                apply(1'b1, 2'b11, 0, 0, 1'b0, 0);
                chk("R5 ret pc", pc, exp_asr);
                chk("R5 ret depth", depth, 0);
                chk("R5 asr kept", dm_rdata, exp_asr & 8'hFF);
                exp_pc = exp_asr;
            end
        end

        // overflow: R6
        apply(1'b1, 2'b01, 1, 12'h123, 1'b0, 0);
        apply(1'b1, 2'b10, 2, 12'h456, 1'b0, 0);
        exp_asr = 12'h125;
        apply(1'b1, 2'b10, 1, 12'h1FF, 1'b0, 0);
        chk("R6 hang", hang_rst, 1);
        chk("R6 pc", pc, 0);
        chk("R6 depth", depth, 0);
        chk("R6 asr kept", dm_rdata, exp_asr & 8'hFF);
        apply(1'b1, 2'b00, 3, 0, 1'b0, 0);
        chk("R8 pulse ends", hang_rst, 0);
        chk("R8 step ignored", pc, 0);

        // underflow: R7
        apply(1'b1, 2'b01, 1, 12'h2AA, 1'b0, 0);
        apply(1'b1, 2'b11, 1, 0, 1'b0, 0);
        chk("R7 hang", hang_rst, 1);
        chk("R7 pc", pc, 0);
        chk("R7 depth", depth, 0);
        apply(1'b1, 2'b01, 1, 12'h3C3, 1'b0, 0);
        chk("R8 pulse ends", hang_rst, 0);
        chk("R8 jump ignored", pc, 0);

        // call and data-memory write together: R10
        apply(1'b1, 2'b01, 1, 12'h0F0, 1'b0, 0);
        apply(1'b1, 2'b10, 3, 12'h010, 1'b1, 8'h3C);
        chk("R10 save wins", dm_rdata, 8'hF3);
        // R9 write while nested changes low byte used by return
        apply(1'b0, 2'b00, 0, 0, 1'b1, 8'h77);
        chk("R9 dm write", dm_rdata, 8'h77);
        apply(1'b1, 2'b11, 0, 0, 1'b0, 0);
        chk("R9 ret low byte", pc & 8'hFF, 8'h77);

        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule